// File: doc/BRIEF.md
# Reset Clock Start-up Sequencer

This block decides when a processor may leave reset and which clock it runs from while the primary oscillator starts. Any reset request stops the sequence. The request can come from power-on, the watchdog, brown-out or the external pin; the block treats them all the same way. A reset clears the clock-select field to the primary source and drops the primary-running status. While the request is high, the block captures the oscillator mode, the sleep flag and the two-speed enable. When the request is removed, two start-up counters run side by side. The crystal counter counts primary-clock ticks, and it runs only when the mode is a crystal mode. The CPU counter counts internal-clock ticks, and it runs only if the device was asleep when the reset arrived.

The CPU and peripheral clocks are held frozen in phase Q1 until both counters have finished. After that the block waits one more reference cycle and then releases the hold. It raises a one-cycle start pulse, which tells the core to fetch from address 0000h. If two-speed start-up is enabled in a crystal mode, the system clock mux selects the internal RC clock until the crystal count completes. The mux then moves to the primary clock. After release, the clock-select field may be written, and it steers the mux.

Top module: `rcs_top`

## Requirements
- R1: While `rst_req` is high and after the next clock edge, `hold_rst` is 1, `clk_sel` is 2'b00 and `osc_ready` is 0, whatever the reset source or prior state.
- R2: Crystal modes are `osc_mode` 3'b000, 3'b001 and 3'b010. In these modes the block counts `OST_CYCLES` cycles with `pri_tick` high before it treats the primary clock as usable. With no primary ticks, the hold never releases.
- R3: The CPU start-up count of `CPU_CYCLES` internal ticks runs only when `was_asleep` was high during reset. Otherwise it contributes no delay.
- R4: The two counts run concurrently. With both tick inputs high every cycle, `hold_rst` falls after the 3+max(ost,cpu)-th rising edge following the edge that sees `rst_req` low. Here ost is `OST_CYCLES` in crystal modes and 0 otherwise, and cpu is `CPU_CYCLES` when asleep and 0 otherwise.
- R5: `q1_freeze` is high from the first edge after reset removal until release. This period includes the one extra cycle after both counts finish. `q1_freeze` is never high while the hold is released.
- R6: In non-crystal modes (3'b011 to 3'b111) with no sleep, the hold releases on the third edge after reset removal.
- R7: The `sys_mux` encoding is 0 for primary, 1 for secondary and 2 for internal RC. With `two_speed_en` latched high in a crystal mode, `sys_mux` is 2 until `osc_ready` rises and 0 afterwards. Without two-speed, or in a non-crystal mode, `sys_mux` is 0 throughout start-up.
- R8: `osc_ready` rises on the edge where the crystal count completes, which is the (1+`OST_CYCLES`)-th edge with ticks every cycle. In non-crystal modes it rises on the first edge after reset removal.
- R9: A reset request during the sequence restarts both counts from zero. The release timing of R4 then applies from the new reset removal.
- R10: While `hold_rst` is high, writes through `sel_we` are ignored. After release, a write loads `sel_wdata` into `clk_sel` on the next edge. `sys_mux` then shows 0 for 2'b00, 1 for 2'b01 and 2 for 2'b10 or 2'b11.
- R11: `run_start` is high for exactly one cycle, the first cycle with `hold_rst` low. This pulse marks the fetch from 0000h.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Reference clock |
| rst_n | input | 1 | Asynchronous power-on reset, active low |
| rst_req | input | 1 | Reset request from any source, active high |
| was_asleep | input | 1 | Device was in sleep when reset arrived |
| osc_mode | input | 3 | Primary oscillator mode code |
| two_speed_en | input | 1 | Run from the internal RC clock during crystal start-up |
| pri_tick | input | 1 | One-cycle pulse per primary oscillator cycle |
| int_tick | input | 1 | One-cycle pulse per internal RC cycle |
| sel_we | input | 1 | Write strobe for the clock-select field |
| sel_wdata | input | 2 | New clock-select value |
| clk_sel | output | 2 | Clock-select field |
| sys_mux | output | 2 | System clock mux select |
| hold_rst | output | 1 | Device held in reset |
| q1_freeze | output | 1 | CPU and peripheral clocks frozen in Q1 |
| osc_ready | output | 1 | Primary oscillator running |
| run_start | output | 1 | One-cycle pulse starting execution at 0000h |

## Verification
Each result has a fixed due edge, counted from the first edge that sees the reset request low. The status bit is due at edge 1+ost, the release and start pulse at edge 3+max(ost,cpu), and a select write one edge after its strobe. The bench drives inputs on falling edges. It samples every output on each following falling edge and records the edge number at which each result first appears. It compares those numbers with the values it computes from the mode, sleep and two-speed settings. A run with the primary ticks stopped and a run with a reset repeated mid-sequence check that the count waits for ticks and that it restarts from zero.

// File: rtl/rcs_pkg.sv
package rcs_pkg;

  typedef enum logic [1:0] {
    ST_RESET  = 2'd0,
    ST_TIMING = 2'd1,
    ST_JOIN   = 2'd2,
    ST_RUN    = 2'd3
  } seq_state_e;

  localparam logic [1:0] MUX_PRI = 2'd0;
  localparam logic [1:0] MUX_SEC = 2'd1;
  localparam logic [1:0] MUX_INT = 2'd2;

  // Crystal modes need the oscillator start-up count.
  function automatic logic is_crystal(input logic [2:0] mode);
    return (mode <= 3'd2);
  endfunction

  // Clock-select field to system mux code.
  function automatic logic [1:0] sel_to_mux(input logic [1:0] sel);
    logic [1:0] m;
    if (sel == 2'b00)      m = MUX_PRI;
    else if (sel == 2'b01) m = MUX_SEC;
    else                   m = MUX_INT;
    return m;
  endfunction

endpackage

// File: rtl/rcs_timer.sv
module rcs_timer #(
  parameter int LIMIT = 1024
) (
  input  logic clk,
  input  logic rst_n,
  input  logic clear,
  input  logic run,
  input  logic needed,
  input  logic tick,
  output logic done,
  output logic fire
);
  localparam int W = $clog2(LIMIT + 1);
  localparam logic [W-1:0] LIM  = W'(LIMIT);
  localparam logic [W-1:0] LAST = W'(LIMIT - 1);

  logic [W-1:0] cnt;
  logic         at_lim;
  logic         step;

  assign at_lim = (cnt == LIM);
  assign step   = run && needed && tick && !at_lim;
  assign done   = !needed || at_lim;
  assign fire   = step && (cnt == LAST);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      cnt <= '0;
    else if (clear)  cnt <= '0;
    else if (step)   cnt <= cnt + 1'b1;
  end

  a_r2_cnt_bound: assert property (@(posedge clk) disable iff (!rst_n)
    cnt <= LIM);

  a_r9_clear_restarts: assert property (@(posedge clk) disable iff (!rst_n)
    clear |=> (cnt == '0));

  a_r2_fire_completes: assert property (@(posedge clk) disable iff (!rst_n)
    (fire && !clear) |=> done);

endmodule

// File: rtl/rcs_seq.sv
module rcs_seq
  import rcs_pkg::*;
(
  input  logic       clk,
  input  logic       rst_n,
  input  logic       rst_req,
  input  logic       ost_done,
  input  logic       cpu_done,
  output seq_state_e state,
  output logic       timing,
  output logic       hold_rst,
  output logic       q1_freeze,
  output logic       run_start
);
  seq_state_e nxt;
  logic       both_done;

  assign both_done = ost_done && cpu_done;

  always_comb begin
    nxt = state;
    if (rst_req) nxt = ST_RESET;
    else begin
      case (state)
        ST_RESET:  nxt = ST_TIMING;
        ST_TIMING: nxt = both_done ? ST_JOIN : ST_TIMING;
        ST_JOIN:   nxt = ST_RUN;
        default:   nxt = ST_RUN;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state     <= ST_RESET;
      run_start <= 1'b0;
    end else begin
      state     <= nxt;
      run_start <= (state == ST_JOIN) && !rst_req;
    end
  end

  assign timing    = (state == ST_TIMING);
  assign hold_rst  = (state != ST_RUN);
  assign q1_freeze = (state == ST_TIMING) || (state == ST_JOIN);

  a_r4_join_needs_both: assert property (@(posedge clk) disable iff (!rst_n)
    (state == ST_JOIN) |-> $past(both_done));

  a_r5_freeze_within_hold: assert property (@(posedge clk) disable iff (!rst_n)
    q1_freeze |-> hold_rst);

  a_r11_start_on_release: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(hold_rst) |-> run_start);

  a_r11_single_pulse: assert property (@(posedge clk) disable iff (!rst_n)
    run_start |=> !run_start);

endmodule

// File: rtl/rcs_top.sv
module rcs_top
  import rcs_pkg::*;
#(
  parameter int OST_CYCLES = 1024,
  parameter int CPU_CYCLES = 8
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       rst_req,
  input  logic       was_asleep,
  input  logic [2:0] osc_mode,
  input  logic       two_speed_en,
  input  logic       pri_tick,
  input  logic       int_tick,
  input  logic       sel_we,
  input  logic [1:0] sel_wdata,
  output logic [1:0] clk_sel,
  output logic [1:0] sys_mux,
  output logic       hold_rst,
  output logic       q1_freeze,
  output logic       osc_ready,
  output logic       run_start
);
  seq_state_e state;
  logic       timing;
  logic       latch_en;
  logic [2:0] mode_q;
  logic       asleep_q;
  logic       ts_q;
  logic       xtal;
  logic       ost_done, ost_fire;
  logic       cpu_done, cpu_fire;
  logic       two_speed_active;

  assign latch_en = rst_req || (state == ST_RESET);
  assign xtal     = is_crystal(mode_q);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      mode_q   <= 3'd0;
      asleep_q <= 1'b0;
      ts_q     <= 1'b0;
    end else if (latch_en) begin
      mode_q   <= osc_mode;
      asleep_q <= was_asleep;
      ts_q     <= two_speed_en;
    end
  end

  rcs_timer #(.LIMIT(OST_CYCLES)) u_ost (
    .clk(clk), .rst_n(rst_n), .clear(latch_en), .run(timing),
    .needed(xtal), .tick(pri_tick), .done(ost_done), .fire(ost_fire)
  );

  rcs_timer #(.LIMIT(CPU_CYCLES)) u_cpu (
    .clk(clk), .rst_n(rst_n), .clear(latch_en), .run(timing),
    .needed(asleep_q), .tick(int_tick), .done(cpu_done), .fire(cpu_fire)
  );

  rcs_seq u_seq (
    .clk(clk), .rst_n(rst_n), .rst_req(rst_req),
    .ost_done(ost_done), .cpu_done(cpu_done),
    .state(state), .timing(timing), .hold_rst(hold_rst),
    .q1_freeze(q1_freeze), .run_start(run_start)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                                 osc_ready <= 1'b0;
    else if (rst_req)                           osc_ready <= 1'b0;
    else if (ost_fire)                          osc_ready <= 1'b1;
    else if ((state == ST_RESET) && !xtal)      osc_ready <= 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                     clk_sel <= 2'b00;
    else if (rst_req)               clk_sel <= 2'b00;
    else if (sel_we && !hold_rst)   clk_sel <= sel_wdata;
  end

  assign two_speed_active = ts_q && xtal && !osc_ready;
  assign sys_mux = two_speed_active ? MUX_INT : sel_to_mux(clk_sel);

  a_r1_reset_state: assert property (@(posedge clk) disable iff (!rst_n)
    rst_req |=> (hold_rst && (clk_sel == 2'b00) && !osc_ready));

  a_r8_ready_before_release: assert property (@(posedge clk) disable iff (!rst_n)
    !hold_rst |-> osc_ready);

  a_r7_primary_after_ready: assert property (@(posedge clk) disable iff (!rst_n)
    (osc_ready && (clk_sel == 2'b00)) |-> (sys_mux == MUX_PRI));

  a_r10_sel_locked: assert property (@(posedge clk) disable iff (!rst_n)
    (hold_rst && !rst_req) |=> $stable(clk_sel));

  a_r3_cpu_only_asleep: assert property (@(posedge clk) disable iff (!rst_n)
    cpu_fire |-> asleep_q);

endmodule

// File: tb/test_rcs_top.sv
module test_rcs_top;
  localparam int OST = 12;
  localparam int CPU = 5;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic rst_req = 1'b0;
  logic was_asleep = 1'b0;
  logic [2:0] osc_mode = 3'd0;
  logic two_speed_en = 1'b0;
  logic pri_tick = 1'b0;
  logic int_tick = 1'b0;
  logic sel_we = 1'b0;
  logic [1:0] sel_wdata = 2'b00;
  logic [1:0] clk_sel, sys_mux;
  logic hold_rst, q1_freeze, osc_ready, run_start;

  int checks = 0;
  int failures = 0;

  always #2 clk = ~clk;

  rcs_top #(.OST_CYCLES(OST), .CPU_CYCLES(CPU)) i_rcs_top (
    .clk(clk), .rst_n(rst_n), .rst_req(rst_req), .was_asleep(was_asleep),
    .osc_mode(osc_mode), .two_speed_en(two_speed_en), .pri_tick(pri_tick),
    .int_tick(int_tick), .sel_we(sel_we), .sel_wdata(sel_wdata),
    .clk_sel(clk_sel), .sys_mux(sys_mux), .hold_rst(hold_rst),
    .q1_freeze(q1_freeze), .osc_ready(osc_ready), .run_start(run_start)
  );

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      failures++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  function automatic int exp_release(input int mode, input int asleep);
    int o = (mode < 3) ? OST : 0;
    int c = asleep ? CPU : 0;
    return 3 + ((o > c) ? o : c);
  endfunction

  task automatic enter_reset(input int mode, input int asleep, input int ts);
    @(negedge clk);
    rst_req = 1'b1; osc_mode = 3'(mode); was_asleep = asleep[0];
    two_speed_en = ts[0]; pri_tick = 1'b1; int_tick = 1'b1;
    @(negedge clk); @(negedge clk);
    chk(hold_rst && clk_sel == 2'b00 && !osc_ready, "R1 reset state",
        {hold_rst, clk_sel, osc_ready}, 8);
  endtask

  task automatic run_seq(input int mode, input int asleep, input int ts);
    int rel, rdy, got_rel, got_rdy, mux_bad, frz_bad, pulse_bad;
    bit xt;
    xt = (mode < 3);
    rel = exp_release(mode, asleep);
    rdy = 1 + (xt ? OST : 0);
    got_rel = -1; got_rdy = -1; mux_bad = 0; frz_bad = 0; pulse_bad = 0;
    enter_reset(mode, asleep, ts);
    rst_req = 1'b0;
    for (int n = 1; n <= rel + 2; n++) begin
      @(negedge clk);
      if (got_rel < 0 && !hold_rst) got_rel = n;
      if (got_rdy < 0 && osc_ready) got_rdy = n;
      if (int'(sys_mux) != ((ts != 0 && xt && n < rdy) ? 2 : 0)) mux_bad++;
      if (q1_freeze != (n < rel)) frz_bad++;
      if (run_start != (n == rel)) pulse_bad++;
    end
    if (xt) chk(got_rel == rel, "R2 R4 crystal release edge", got_rel, rel);
    else if (asleep != 0) chk(got_rel == rel, "R3 R4 sleep release edge", got_rel, rel);
    else chk(got_rel == rel, "R6 fast release edge", got_rel, rel);
    chk(got_rdy == rdy, "R8 ready edge", got_rdy, rdy);
    chk(mux_bad == 0, "R7 system mux", mux_bad, 0);
    chk(frz_bad == 0, "R5 q1 freeze span", frz_bad, 0);
    chk(pulse_bad == 0, "R11 start pulse", pulse_bad, 0);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    failures++;
    $display("FAIL watchdog actual=%0d expected=%0d", 1, 0);
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    int got, waited;
    repeat (3) @(negedge clk);
    chk(hold_rst && clk_sel == 2'b00 && !osc_ready && !run_start,
        "R1 power-on state", {hold_rst, clk_sel, osc_ready}, 8);
    rst_n = 1'b1;

    for (int m = 0; m < 8; m++)
      for (int s = 0; s < 2; s++)
        for (int t = 0; t < 2; t++)
          run_seq(m, s, t);

    // R2: no primary ticks, crystal mode -> held
    enter_reset(1, 0, 0);
    pri_tick = 1'b0; rst_req = 1'b0;
    waited = 0;
    for (int n = 0; n < 40; n++) begin
      @(negedge clk);
      if (!hold_rst || osc_ready) waited++;
    end
    chk(waited == 0, "R2 held without ticks", waited, 0);
    pri_tick = 1'b1;
    got = -1;
    for (int n = 1; n <= OST + 4; n++) begin
      @(negedge clk);
      if (got < 0 && !hold_rst) got = n;
    end
    chk(got == OST + 2, "R2 release after ticks resume", got, OST + 2);

    // R9: reset again mid-sequence restarts counts
    enter_reset(2, 1, 0);
    rst_req = 1'b0;
    repeat (7) @(negedge clk);
    rst_req = 1'b1;
    @(negedge clk);
    chk(hold_rst && !osc_ready, "R9 re-reset holds", {hold_rst, osc_ready}, 2);
    rst_req = 1'b0;
    got = -1;
    for (int n = 1; n <= OST + 6; n++) begin
      @(negedge clk);
      if (got < 0 && !hold_rst) got = n;
    end
    chk(got == 3 + OST, "R9 restart release edge", got, 3 + OST);

    // R10: writes ignored while held, accepted after release
    enter_reset(0, 0, 0);
    rst_req = 1'b0;
    sel_we = 1'b1; sel_wdata = 2'b10;
    repeat (4) @(negedge clk);
    sel_we = 1'b0;
    chk(clk_sel == 2'b00 && hold_rst, "R10 write ignored in hold", clk_sel, 0);
    repeat (OST + 2) @(negedge clk);
    chk(!hold_rst, "R10 released", hold_rst, 0);
    sel_we = 1'b1; sel_wdata = 2'b01;
    @(negedge clk);
    chk(clk_sel == 2'b01 && sys_mux == 2'd1, "R10 secondary select", sys_mux, 1);
    sel_wdata = 2'b11;
    @(negedge clk);
    chk(clk_sel == 2'b11 && sys_mux == 2'd2, "R10 internal select", sys_mux, 2);
    sel_wdata = 2'b00;
    @(negedge clk);
    sel_we = 1'b0;
    chk(sys_mux == 2'd0, "R10 primary select", sys_mux, 0);
    rst_req = 1'b1;
    @(negedge clk);
    chk(clk_sel == 2'b00 && hold_rst, "R1 reset from run", clk_sel, 0);

    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule